// File: doc/BRIEF.md
# H-bridge switch state decoder

This block converts two logic-level control inputs per channel into the four gate enables of one H-bridge: a high-side and a low-side switch for leg A, and the same pair for leg B. Two channels are built by default. Each control input first passes a glitch filter that rejects levels held for fewer than a set number of clock cycles. The filtered pair is then decoded into a three-level drive (positive, negative, or a damped zero state in which both low sides conduct). Last, each leg goes through a dead-time stage that keeps both of its switches open for a fixed number of cycles before either one closes.

A mode input ties the two legs of every channel together so that they switch as one for higher current. In that mode the two control inputs of a channel must agree; if they do not, the channel is opened and flagged. The tri-state enable and a kill input from the protection supervisor both open every switch on the next clock edge. This path does not wait for the filter or the dead time. All timing is counted in cycles of the system clock.

Top module: `hbridge_decoder`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all gate enables and all mismatch flags are 0.
- R2: In bridge mode (par_i=0) with en_i=1 and kill_i=0, a settled input pair gives these enables. (a,b)=(0,0) turns on both low sides only. (0,1) turns on high side B and low side A only. (1,0) turns on high side A and low side B only.
- R3: In bridge mode, the pair (1,1) opens all four switches of the channel. Both high sides of a channel are never on one cycle after a cycle with par_i=0.
- R4: In parallel mode (par_i=1) with equal inputs, both legs are driven alike. Input 1 turns on both high sides, and input 0 turns on both low sides.
- R5: In parallel mode, unequal filtered inputs set par_err_o for that channel one cycle later. While par_err_o is 1, all four enables of that channel are 0.
- R6: With en_i=0, every gate enable is 0 from the next clock edge on, whatever the data inputs do.
- R7: With kill_i=1, every gate enable is 0 from the next clock edge on, whatever the data inputs do.
- R8: A control input level held for fewer than MIN_PW consecutive clock edges is ignored. A level held for MIN_PW edges is taken up at the MIN_PW-th edge.
- R9: A switch turns on only after both switches of its leg have been off for at least DEAD_CYC cycles. The high and low switch of a leg are never on together.
- R10: When a leg moves from one on-state to the other, it opens at edge MIN_PW+1 after the input change. The new switch closes at edge MIN_PW+1+DEAD_CYC. A leg whose target state does not change holds its state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Tri-state enable; 0 opens every switch |
| kill_i | input | 1 | Global disable from protection; 1 opens every switch |
| par_i | input | 1 | 1 = both legs of each channel driven as one (parallel mode) |
| in_a_i | input | N_CH | Control input A per channel |
| in_b_i | input | N_CH | Control input B per channel |
| hs_a_o | output | N_CH | High-side enable, leg A |
| hs_b_o | output | N_CH | High-side enable, leg B |
| ls_a_o | output | N_CH | Low-side enable, leg A |
| ls_b_o | output | N_CH | Low-side enable, leg B |
| par_err_o | output | N_CH | Parallel-mode input mismatch flag per channel |

## Verification
The bench builds the block with two channels, MIN_PW=4 and DEAD_CYC=3. With these short windows the bench can sweep every joint input code of both channels in both modes. It can also test pulses exactly one cycle below and at the filter threshold. Every cycle of a leg reversal, from the input edge through the dead gap to the new switch closing, can be checked in a few dozen clocks. A monitor running for the whole test checks each switch turn-on against the length of the off gap before it.

// File: rtl/hb_pkg.sv
package hb_pkg;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } leg_e;

    typedef struct packed {
        leg_e leg_a;
        leg_e leg_b;
        logic err;
    } chan_req_t;

    // Map one filtered input pair onto the target state of each leg.
    function automatic chan_req_t hb_decode(logic a, logic b, logic par, logic off);
        chan_req_t r;
        r.leg_a = LEG_OFF;
        r.leg_b = LEG_OFF;
        r.err   = par & (a ^ b);
        if (!off) begin
            if (par) begin
                if (!r.err) begin
                    if (a) begin
                        r.leg_a = LEG_HIGH;
                        r.leg_b = LEG_HIGH;
                    end else begin
                        r.leg_a = LEG_LOW;
                        r.leg_b = LEG_LOW;
                    end
                end
            end else begin
                case ({a, b})
                    2'b00: begin r.leg_a = LEG_LOW;  r.leg_b = LEG_LOW;  end
                    2'b01: begin r.leg_a = LEG_LOW;  r.leg_b = LEG_HIGH; end
                    2'b10: begin r.leg_a = LEG_HIGH; r.leg_b = LEG_LOW;  end
                    default: begin r.leg_a = LEG_OFF; r.leg_b = LEG_OFF; end
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/hb_glitch_filter.sv
module hb_glitch_filter #(
    parameter int MIN_PW = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raw_i,
    output logic filt_o
);
    localparam int CW = (MIN_PW < 2) ? 1 : $clog2(MIN_PW);

    typedef struct packed {
        logic          val;
        logic [CW-1:0] cnt;
    } filt_state_t;

    filt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i != st_q.val) begin
            if (st_q.cnt == CW'(MIN_PW - 1)) begin
                st_d.val = raw_i;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign filt_o = st_q.val;

    // R8: the filtered level only ever moves to a value the input held
    a_r8_follows_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(filt_o) |-> (filt_o == $past(raw_i)));

endmodule

// File: rtl/hb_leg_dt.sv
module hb_leg_dt
    import hb_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  leg_e target_i,
    input  logic force_i,
    output logic hi_o,
    output logic lo_o
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    typedef struct packed {
        leg_e          cur;
        logic [DW-1:0] cnt;
    } leg_state_t;

    leg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_i) begin
            st_d.cur = LEG_OFF;
        end else if (target_i != st_q.cur) begin
            if (st_q.cur != LEG_OFF) begin
                st_d.cur = LEG_OFF;
            end else if (st_q.cnt == DW'(DEAD_CYC)) begin
                st_d.cur = target_i;
            end
        end
        if (st_d.cur == LEG_OFF) begin
            if (st_q.cnt != DW'(DEAD_CYC)) st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{cur: LEG_OFF, cnt: '0};
        else         st_q <= st_d;
    end

    assign hi_o = (st_q.cur == LEG_HIGH);
    assign lo_o = (st_q.cur == LEG_LOW);

    // Independent gap counter, fed only by the gate outputs.
    logic [DW-1:0] gap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             gap_q <= '0;
        else if (hi_o || lo_o)   gap_q <= '0;
        else if (gap_q != DW'(DEAD_CYC)) gap_q <= gap_q + 1'b1;
    end

    // R9: every turn-on follows a full dead gap
    a_r9_dead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(hi_o) || $rose(lo_o)) |-> (gap_q == DW'(DEAD_CYC)));

    // R9: no direct swap between the two switches of a leg
    a_r9_no_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(hi_o) |-> !lo_o);

endmodule

// File: rtl/hbridge_decoder.sv
module hbridge_decoder
    import hb_pkg::*;
#(
    parameter int N_CH     = 2,
    parameter int MIN_PW   = 4,
    parameter int DEAD_CYC = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            en_i,
    input  logic            kill_i,
    input  logic            par_i,
    input  logic [N_CH-1:0] in_a_i,
    input  logic [N_CH-1:0] in_b_i,
    output logic [N_CH-1:0] hs_a_o,
    output logic [N_CH-1:0] hs_b_o,
    output logic [N_CH-1:0] ls_a_o,
    output logic [N_CH-1:0] ls_b_o,
    output logic [N_CH-1:0] par_err_o
);
    typedef struct packed {
        logic [N_CH-1:0] err;
    } top_state_t;

    top_state_t      st_d, st_q;
    logic            force_w;
    logic [N_CH-1:0] fa_w, fb_w;
    chan_req_t       req_w [N_CH];

    assign force_w = kill_i | ~en_i;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        hb_glitch_filter #(.MIN_PW(MIN_PW)) u_filt_a (
            .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(in_a_i[c]), .filt_o(fa_w[c]));
        hb_glitch_filter #(.MIN_PW(MIN_PW)) u_filt_b (
            .clk_i(clk_i), .rst_ni(rst_ni), .raw_i(in_b_i[c]), .filt_o(fb_w[c]));

        assign req_w[c] = hb_decode(fa_w[c], fb_w[c], par_i, force_w);

        hb_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg_a (
            .clk_i(clk_i), .rst_ni(rst_ni), .target_i(req_w[c].leg_a),
            .force_i(force_w), .hi_o(hs_a_o[c]), .lo_o(ls_a_o[c]));
        hb_leg_dt #(.DEAD_CYC(DEAD_CYC)) u_leg_b (
            .clk_i(clk_i), .rst_ni(rst_ni), .target_i(req_w[c].leg_b),
            .force_i(force_w), .hi_o(hs_b_o[c]), .lo_o(ls_b_o[c]));

        // R3: bridge mode never closes both high sides of a channel
        a_r3_no_dual_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !par_i |=> !(hs_a_o[c] && hs_b_o[c]));

        // R5: a flagged channel has every switch open
        a_r5_err_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
            par_err_o[c] |-> !(hs_a_o[c] || hs_b_o[c] || ls_a_o[c] || ls_b_o[c]));
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < N_CH; c++) begin
            st_d.err[c] = req_w[c].err;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign par_err_o = st_q.err;

    // R6 and R7: disable or kill opens all switches at the next edge
    a_r7_force_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (kill_i || !en_i) |=> ((hs_a_o | hs_b_o | ls_a_o | ls_b_o) == '0));

endmodule

// File: tb/hbridge_decoder_bench.sv
module hbridge_decoder_bench;
    localparam int N_CH = 2;
    localparam int MIN_PW = 4;
    localparam int DEAD_CYC = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b1, kill = 1'b0, par = 1'b0;
    logic [N_CH-1:0] in_a = '0, in_b = '0;
    logic [N_CH-1:0] hs_a, hs_b, ls_a, ls_b, perr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hbridge_decoder #(.N_CH(N_CH), .MIN_PW(MIN_PW), .DEAD_CYC(DEAD_CYC)) u_hbridge_decoder (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .kill_i(kill), .par_i(par),
        .in_a_i(in_a), .in_b_i(in_b), .hs_a_o(hs_a), .hs_b_o(hs_b),
        .ls_a_o(ls_a), .ls_b_o(ls_b), .par_err_o(perr));

    // {hsA, hsB, lsA, lsB, err} for one channel
    function automatic logic [4:0] obs(int c);
        return {hs_a[c], hs_b[c], ls_a[c], ls_b[c], perr[c]};
    endfunction

    function automatic logic [4:0] model(logic a, logic b, logic p);
        if (p) begin
            if (a != b) return 5'b00001;
            return a ? 5'b11000 : 5'b00110;
        end
        case ({a, b})
            2'b00: return 5'b00110;
            2'b01: return 5'b01100;
            2'b10: return 5'b10010;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic string req_of(logic a, logic b, logic p);
        if (p) return (a != b) ? "R5" : "R4";
        return (a && b) ? "R3" : "R2";
    endfunction

    task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Dead-gap monitor over all four legs (R9)
    logic [3:0] phi = '0, plo = '0;
    int run [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        logic [3:0] hi, lo;
        hi = {hs_b, hs_a};
        lo = {ls_b, ls_a};
        for (int l = 0; l < 4; l++) begin
            if (hi[l] && lo[l]) begin
                checks++; errors++;
                $display("FAIL R9: leg %0d both switches on", l);
            end
            if ((hi[l] && !phi[l]) || (lo[l] && !plo[l])) begin
                checks++;
                if (run[l] < DEAD_CYC) begin
                    errors++;
                    $display("FAIL R9: leg %0d gap %0d expected >= %0d", l, run[l], DEAD_CYC);
                end
            end
            if (!hi[l] && !lo[l]) run[l] = run[l] + 1;
            else run[l] = 0;
        end
        phi = hi;
        plo = lo;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic seen;
        cyc(3);
        chk("R1", obs(0), 5'b0);
        chk("R1", obs(1), 5'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", obs(0), 5'b0);
        chk("R1", obs(1), 5'b0);

        // Exhaustive joint sweep of both channels in both modes (R2 R3 R4 R5)
        for (int p = 0; p < 2; p++) begin
            for (int code = 0; code < 16; code++) begin
                par = p[0];
                in_a = {code[3], code[1]};
                in_b = {code[2], code[0]};
                cyc(20);
                for (int c = 0; c < N_CH; c++)
                    chk(req_of(in_a[c], in_b[c], par), obs(c), model(in_a[c], in_b[c], par));
            end
        end

        // R10: reversal timing on channel 0, channel 1 held in damped state
        par = 1'b0; in_a = 2'b01; in_b = 2'b00;
        cyc(20);
        in_a = 2'b00; in_b = 2'b01;
        for (int k = 1; k <= MIN_PW + 1 + DEAD_CYC; k++) begin
            cyc(1);
            if (k <= MIN_PW) chk("R10", obs(0), 5'b10010);
            else if (k < MIN_PW + 1 + DEAD_CYC) chk("R10", obs(0), 5'b00000);
            else chk("R10", obs(0), 5'b01100);
            chk("R10", obs(1), 5'b00110);
        end

        // R8: pulse one edge short of MIN_PW is dropped
        in_a = 2'b00; in_b = 2'b00;
        cyc(20);
        in_a[0] = 1'b1;
        cyc(MIN_PW - 1);
        in_a[0] = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 15; k++) begin
            cyc(1);
            if (obs(0) != 5'b00110) seen = 1'b1;
        end
        chk("R8", {4'b0, seen}, 5'b0);

        // R8: pulse of exactly MIN_PW edges is taken up
        in_a[0] = 1'b1;
        cyc(MIN_PW);
        in_a[0] = 1'b0;
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            cyc(1);
            if (hs_a[0]) seen = 1'b1;
        end
        chk("R8", {4'b0, seen}, 5'b1);
        chk("R8", obs(0), 5'b00110);

        // R7: kill opens everything at the next edge, inputs ignored meanwhile
        in_a = 2'b01; in_b = 2'b10;
        cyc(20);
        kill = 1'b1;
        cyc(1);
        chk("R7", obs(0), 5'b0);
        chk("R7", obs(1), 5'b0);
        in_a = 2'b00; in_b = 2'b00;
        cyc(20);
        chk("R7", obs(0), 5'b0);
        chk("R7", obs(1), 5'b0);
        kill = 1'b0;
        cyc(20);
        chk("R7", obs(0), 5'b00110);

        // R6: tri-state enable low opens everything at the next edge
        in_a = 2'b10; in_b = 2'b01;
        cyc(20);
        en = 1'b0;
        cyc(1);
        chk("R6", obs(0), 5'b0);
        chk("R6", obs(1), 5'b0);
        in_a = 2'b11; in_b = 2'b00;
        cyc(20);
        chk("R6", obs(0), 5'b0);
        chk("R6", obs(1), 5'b0);
        en = 1'b1;
        cyc(20);
        chk("R6", obs(0), 5'b10010);
        chk("R6", obs(1), 5'b10010);

        // R5: mismatch in parallel mode on one channel only, other unaffected
        par = 1'b1; in_a = 2'b11; in_b = 2'b10;
        cyc(20);
        chk("R5", obs(0), 5'b00001);
        chk("R4", obs(1), 5'b11000);
        in_b = 2'b11;
        cyc(20);
        chk("R5", obs(0), 5'b11000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule